// File: doc/BRIEF.md
# Triggered Ringdown Capture Sequencer

This block runs one decay measurement from start to end. An analog-to-digital converter delivers samples on every clock, and an external trigger, which is not related to the clock, marks the moment a decay begins. The sequencer brings the trigger into the clock domain and detects its rising edge. It waits a programmable holdoff so that switching transients are skipped. It then forwards exactly one fixed-length block of samples to a downstream transform engine.

After the block is forwarded, the sequencer watches the transform's output bin stream and captures the real and imaginary parts of one selected bin. It starts a ratio divider with those two operands and waits for the quotient. The quotient goes into an output register that keeps its value until the next measurement replaces it, so a slow reader can sample it at leisure. A one-cycle reset is then sent to the transform engine and the sequencer rearms.

A busy flag covers the whole measurement. Trigger edges that arrive while busy is high are dropped.

Top module: `ringdown_seq`

## Requirements
- R1: A rising edge on `trig_in`, after a two-flop synchroniser, starts a measurement when the sequencer is idle. `busy` is high from that start until the sequencer returns to idle, and it is low while idle.
- R2: The first forwarded sample has `xf_valid` high exactly HOLDOFF_CYC+1 cycles after `busy` rises, provided `adc_valid` is held high.
- R3: Exactly CAPTURE_LEN samples are forwarded per measurement. Only cycles with `adc_valid` high are counted and forwarded. `xf_last` is high together with `xf_valid` on the final sample only.
- R4: Each forwarded sample is registered: `xf_data` carries the `adc_data` value that was accepted one cycle earlier, and samples keep their arrival order.
- R5: After the capture, the sequencer latches `bin_re`/`bin_im` into `div_num`/`div_den` on the first `bin_valid` whose `bin_idx` equals BIN_SEL. Bins with any other index are ignored, and so are bins that arrive outside that waiting phase.
- R6: `div_start` pulses high for exactly one cycle, in the cycle after the operands are latched, once per measurement.
- R7: A `div_done` during the divide phase loads `div_quot` into `result`, and `result_valid` is high for that one cycle only.
- R8: `xf_rst` pulses high for one cycle, in the cycle right after `result_valid`. `busy` is already low in that cycle.
- R9: Trigger edges that arrive while `busy` is high are ignored and start no further measurement.
- R10: `result` changes only when `result_valid` is high. A `div_done` outside the divide phase changes neither `result` nor `result_valid`.
- R11: After reset, `busy`, `xf_valid`, `xf_last`, `div_start`, `xf_rst` and `result_valid` are low, and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous event trigger |
| adc_data | input | SAMPLE_W | Converter sample |
| adc_valid | input | 1 | Sample present this cycle |
| xf_data | output | SAMPLE_W | Sample sent to the transform |
| xf_valid | output | 1 | Forwarded sample valid |
| xf_last | output | 1 | Final sample of the block |
| xf_rst | output | 1 | One-cycle transform reset |
| bin_valid | input | 1 | Transform bin present |
| bin_idx | input | IDX_W | Index of that bin |
| bin_re | input | XFORM_W | Real part of the bin |
| bin_im | input | XFORM_W | Imaginary part of the bin |
| div_start | output | 1 | Divider start pulse |
| div_num | output | XFORM_W | Latched numerator (real part) |
| div_den | output | XFORM_W | Latched denominator (imaginary part) |
| div_done | input | 1 | Divider finished |
| div_quot | input | RESULT_W | Divider quotient |
| result | output | RESULT_W | Held measurement result |
| result_valid | output | 1 | Result updated this cycle |
| busy | output | 1 | Measurement in progress |

## Verification
The bench builds the block with HOLDOFF_CYC=5 and CAPTURE_LEN=16. With these values the holdoff-to-first-sample distance and the final-sample marker can be counted on short runs, and several complete measurements fit back to back. BIN_SEL stays 1, so the bins on either side of it (indices 0 and 2) can be offered with different values to show that only the chosen one is latched. One run gaps `adc_valid` to show that the count follows accepted samples rather than cycles.

// File: rtl/ringdown_pkg.sv
package ringdown_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HOLDOFF = 3'd1,
    ST_CAPTURE = 3'd2,
    ST_WAITXF  = 3'd3,
    ST_DIVIDE  = 3'd4,
    ST_LATCH   = 3'd5
  } seq_state_t;
endpackage

// File: rtl/rd_trig_sync.sv
module rd_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_async,
  output logic trig_rise
);
  logic [SYNC_STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[SYNC_STAGES-1:0], trig_async};
  end

  assign trig_rise = sr[SYNC_STAGES-1] & ~sr[SYNC_STAGES];
endmodule

// File: rtl/rd_sample_gate.sv
module rd_sample_gate #(
  parameter int SAMPLE_W    = 14,
  parameter int CAPTURE_LEN = 8192,
  localparam int CNT_W      = $clog2(CAPTURE_LEN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_en,
  input  logic [SAMPLE_W-1:0] adc_data,
  input  logic                adc_valid,
  output logic [SAMPLE_W-1:0] xf_data,
  output logic                xf_valid,
  output logic                xf_last,
  output logic                cap_done
);
  logic [CNT_W-1:0] cnt;
  logic             take;

  assign take     = cap_en & adc_valid;
  assign cap_done = take & (cnt == CNT_W'(CAPTURE_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      xf_data  <= '0;
      xf_valid <= 1'b0;
      xf_last  <= 1'b0;
    end else begin
      xf_valid <= take;
      xf_last  <= cap_done;
      if (take) xf_data <= adc_data;
      if (!cap_en)   cnt <= '0;
      else if (take) cnt <= cnt + 1'b1;
    end
  end

  // R4
  fwd_src_chk: assert property (@(posedge clk) disable iff (rst)
    xf_valid |-> $past(adc_valid));

  // R3
  last_in_valid_chk: assert property (@(posedge clk) disable iff (rst)
    xf_last |-> xf_valid);
endmodule

// File: rtl/rd_bin_latch.sv
module rd_bin_latch #(
  parameter int XFORM_W = 28,
  parameter int IDX_W   = 13,
  parameter int BIN_SEL = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm,
  input  logic               bin_valid,
  input  logic [IDX_W-1:0]   bin_idx,
  input  logic [XFORM_W-1:0] bin_re,
  input  logic [XFORM_W-1:0] bin_im,
  output logic [XFORM_W-1:0] op_num,
  output logic [XFORM_W-1:0] op_den,
  output logic               hit
);
  assign hit = arm & bin_valid & (bin_idx == IDX_W'(BIN_SEL));

  always_ff @(posedge clk) begin
    if (rst) begin
      op_num <= '0;
      op_den <= '0;
    end else if (hit) begin
      op_num <= bin_re;
      op_den <= bin_im;
    end
  end

  // R5
  ops_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(hit) |-> ($stable(op_num) && $stable(op_den)));
endmodule

// File: rtl/ringdown_seq.sv
module ringdown_seq
  import ringdown_pkg::*;
#(
  parameter int SAMPLE_W    = 14,
  parameter int XFORM_W     = 28,
  parameter int RESULT_W    = 16,
  parameter int HOLDOFF_CYC = 160,
  parameter int CAPTURE_LEN = 8192,
  parameter int BIN_SEL     = 1,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(CAPTURE_LEN),
  localparam int HOLD_W     = $clog2(HOLDOFF_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trig_in,
  input  logic [SAMPLE_W-1:0] adc_data,
  input  logic                adc_valid,
  output logic [SAMPLE_W-1:0] xf_data,
  output logic                xf_valid,
  output logic                xf_last,
  output logic                xf_rst,
  input  logic                bin_valid,
  input  logic [IDX_W-1:0]    bin_idx,
  input  logic [XFORM_W-1:0]  bin_re,
  input  logic [XFORM_W-1:0]  bin_im,
  output logic                div_start,
  output logic [XFORM_W-1:0]  div_num,
  output logic [XFORM_W-1:0]  div_den,
  input  logic                div_done,
  input  logic [RESULT_W-1:0] div_quot,
  output logic [RESULT_W-1:0] result,
  output logic                result_valid,
  output logic                busy
);
  seq_state_t        state, nxt;
  logic              trig_rise;
  logic              cap_done;
  logic              bin_hit;
  logic [HOLD_W-1:0] hold_cnt;
  logic              hold_end;

  rd_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .trig_async(trig_in), .trig_rise(trig_rise)
  );

  rd_sample_gate #(.SAMPLE_W(SAMPLE_W), .CAPTURE_LEN(CAPTURE_LEN)) u_gate (
    .clk(clk), .rst(rst), .cap_en(state == ST_CAPTURE),
    .adc_data(adc_data), .adc_valid(adc_valid),
    .xf_data(xf_data), .xf_valid(xf_valid), .xf_last(xf_last),
    .cap_done(cap_done)
  );

  rd_bin_latch #(.XFORM_W(XFORM_W), .IDX_W(IDX_W), .BIN_SEL(BIN_SEL)) u_bins (
    .clk(clk), .rst(rst), .arm(state == ST_WAITXF),
    .bin_valid(bin_valid), .bin_idx(bin_idx), .bin_re(bin_re), .bin_im(bin_im),
    .op_num(div_num), .op_den(div_den), .hit(bin_hit)
  );

  assign hold_end = (hold_cnt == HOLD_W'(HOLDOFF_CYC - 1));

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:    if (trig_rise) nxt = ST_HOLDOFF;
      ST_HOLDOFF: if (hold_end)  nxt = ST_CAPTURE;
      ST_CAPTURE: if (cap_done)  nxt = ST_WAITXF;
      ST_WAITXF:  if (bin_hit)   nxt = ST_DIVIDE;
      ST_DIVIDE:  if (div_done)  nxt = ST_LATCH;
      ST_LATCH:                  nxt = ST_IDLE;
      default:                   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      hold_cnt     <= '0;
      busy         <= 1'b0;
      div_start    <= 1'b0;
      result       <= '0;
      result_valid <= 1'b0;
      xf_rst       <= 1'b0;
    end else begin
      state        <= nxt;
      busy         <= (nxt != ST_IDLE);
      hold_cnt     <= (state == ST_HOLDOFF) ? hold_cnt + 1'b1 : '0;
      div_start    <= (state == ST_WAITXF) && bin_hit;
      result_valid <= (state == ST_DIVIDE) && div_done;
      xf_rst       <= (state == ST_LATCH);
      if ((state == ST_DIVIDE) && div_done) result <= div_quot;
    end
  end

  // R1
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(trig_rise));

  // R6
  div_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    div_start |=> !div_start);

  // R7
  rv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> result_valid);

  // R8
  xf_rst_order_chk: assert property (@(posedge clk) disable iff (rst)
    xf_rst |-> ($past(result_valid) && !busy));
endmodule

// File: tb/ringdown_seq_bench.sv
module ringdown_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 14, XW = 28, RW = 16;
  localparam int HOLD = 5, LEN = 16, SEL = 1;
  localparam int IW = $clog2(LEN);

  logic clk = 0, rst = 1, trig_in = 0;
  logic [SW-1:0] adc_data = '0;
  logic adc_valid = 0;
  logic [SW-1:0] xf_data;
  logic xf_valid, xf_last, xf_rst, div_start, result_valid, busy;
  logic bin_valid = 0;
  logic [IW-1:0] bin_idx = '0;
  logic [XW-1:0] bin_re = '0, bin_im = '0;
  logic [XW-1:0] div_num, div_den;
  logic div_done = 0;
  logic [RW-1:0] div_quot = '0, result;

  int errors = 0, checks = 0, cyc = 0;
  int gap_mode = 0, feed = 0;
  int fwd_cnt = 0, last_cnt = 0, last_pos = 0, seq_err = 0;
  int busy_rises = 0, busy_rise_cyc = 0, first_v_cyc = -1;
  logic [SW-1:0] prev_fwd = '0;
  logic prev_busy = 0;

  ringdown_seq #(.SAMPLE_W(SW), .XFORM_W(XW), .RESULT_W(RW), .HOLDOFF_CYC(HOLD),
                 .CAPTURE_LEN(LEN), .BIN_SEL(SEL)) u_ringdown_seq (
    .clk(clk), .rst(rst), .trig_in(trig_in), .adc_data(adc_data), .adc_valid(adc_valid),
    .xf_data(xf_data), .xf_valid(xf_valid), .xf_last(xf_last), .xf_rst(xf_rst),
    .bin_valid(bin_valid), .bin_idx(bin_idx), .bin_re(bin_re), .bin_im(bin_im),
    .div_start(div_start), .div_num(div_num), .div_den(div_den),
    .div_done(div_done), .div_quot(div_quot), .result(result),
    .result_valid(result_valid), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // sample source: value advances only after an accepted sample
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (feed != 0) begin
      if (adc_valid) adc_data <= adc_data + 1'b1;
      adc_valid <= (gap_mode == 0) || (cyc % 3 != 0);
    end else adc_valid <= 1'b0;
  end

  // output monitor
  always @(negedge clk) begin
    prev_busy <= busy;
    if (busy && !prev_busy) begin busy_rises <= busy_rises + 1; busy_rise_cyc <= cyc; end
    if (xf_valid) begin
      if (first_v_cyc < 0) first_v_cyc <= cyc;
      if (fwd_cnt > 0 && xf_data != prev_fwd + 1'b1) seq_err <= seq_err + 1;
      prev_fwd <= xf_data;
      fwd_cnt  <= fwd_cnt + 1;
      if (xf_last) begin last_cnt <= last_cnt + 1; last_pos <= fwd_cnt + 1; end
    end else if (xf_last) last_cnt <= last_cnt + 100;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    fwd_cnt = 0; last_cnt = 0; last_pos = 0; seq_err = 0;
    busy_rises = 0; first_v_cyc = -1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy == 0, "R11 busy", busy, 0);
    chk(xf_valid == 0 && xf_last == 0, "R11 xf_valid/last", xf_valid, 0);
    chk(div_start == 0 && xf_rst == 0, "R11 div_start/xf_rst", div_start, 0);
    chk(result_valid == 0 && result == 0, "R11 result", result, 0);
  endtask

  // one complete measurement
  task automatic t_event(input int gap, input int glitch, input logic [XW-1:0] re,
                         input logic [XW-1:0] im, input logic [RW-1:0] q);
    int guard;
    clr_mon();
    gap_mode = gap; feed = 1;
    trig_in = 1;
    repeat (4) @(negedge clk);
    if (glitch != 0) begin
      // R9: retrigger while busy
      trig_in = 0; repeat (3) @(negedge clk); trig_in = 1;
      // R5: selected index offered before the waiting phase
      bin_valid = 1; bin_idx = IW'(SEL); bin_re = 'h5A5; bin_im = 'h3C3;
      @(negedge clk); bin_valid = 0;
    end
    guard = 0;
    while (fwd_cnt < LEN && guard < 500) begin @(negedge clk); guard++; end
    feed = 0;
    trig_in = 0;
    chk(fwd_cnt == LEN, "R3 forwarded count", fwd_cnt, LEN);
    chk(last_cnt == 1 && last_pos == LEN, "R3 last marker position", last_pos, LEN);
    chk(seq_err == 0, "R4 order/content", seq_err, 0);
    if (gap == 0) chk(first_v_cyc - busy_rise_cyc == HOLD + 1, "R2 holdoff",
                      first_v_cyc - busy_rise_cyc, HOLD + 1);
    // bins 0,1,2 in a row; only index SEL latched
    bin_valid = 1; bin_idx = 0; bin_re = re + 7; bin_im = im + 9;
    @(negedge clk);
    chk(div_start == 0, "R5 no start on other index", div_start, 0);
    bin_idx = IW'(SEL); bin_re = re; bin_im = im;
    @(negedge clk);
    chk(div_start == 1, "R6 div_start", div_start, 1);
    chk(div_num == re && div_den == im, "R5 operands", div_num, re);
    bin_idx = IW'(SEL + 1); bin_re = re + 3; bin_im = im + 4;
    @(negedge clk);
    bin_valid = 0;
    chk(div_start == 0, "R6 single pulse", div_start, 0);
    chk(div_num == re && div_den == im, "R5 operands held", div_den, im);
    repeat (2) @(negedge clk);
    chk(busy == 1, "R1 busy during divide", busy, 1);
    div_done = 1; div_quot = q;
    @(negedge clk);
    div_done = 0; div_quot = ~q;
    chk(result_valid == 1 && result == q, "R7 result load", result, q);
    @(negedge clk);
    chk(result_valid == 0, "R7 valid pulse", result_valid, 0);
    chk(xf_rst == 1, "R8 xf_rst after result", xf_rst, 1);
    chk(busy == 0, "R1 busy low in idle", busy, 0);
    @(negedge clk);
    chk(xf_rst == 0, "R8 xf_rst pulse", xf_rst, 0);
    chk(busy_rises == 1, "R9 one start per event", busy_rises, 1);
  endtask

  // idle behaviour: stray divider completion and bins
  task automatic t_idle_ignore(input logic [RW-1:0] held);
    div_done = 1; div_quot = held ^ 16'hFFFF;
    bin_valid = 1; bin_idx = IW'(SEL);
    @(negedge clk);
    div_done = 0; bin_valid = 0;
    repeat (3) @(negedge clk);
    chk(result == held, "R10 result held", result, held);
    chk(result_valid == 0, "R10 no valid in idle", result_valid, 0);
    chk(busy == 0 && busy_rises == 1, "R9 no restart", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_event(0, 0, 28'd1200, 28'd1000, 16'h2400);
    t_idle_ignore(16'h2400);
    t_event(1, 0, 28'd77, 28'd55, 16'h1234);
    t_event(0, 1, 28'h0ABCDEF, 28'h0123456, 16'hBEEF);
    t_idle_ignore(16'hBEEF);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule